// File: doc/BRIEF.md
# Multi-core interrupt routing controller

The block collects 32 level-sensitive interrupt requests, masks them with an enable register, and steers each one to any subset of 4 cores and any subset of 4 interrupt lines. It drives 16 registered output lines. Output index `N_LINE*core + line` is high when some pending request targets that core and some pending request, possibly a different one, targets that line. The fan-out is computed from a per-core summary and a per-line summary. It is not tracked for each pair separately.

Software uses a single-cycle register port to configure and inspect the block. Read data comes back in the same cycle, combinationally. Each request has one route byte. The low nibble of that byte picks cores and the high nibble picks lines. A 32-bit enable register is changed through separate set and clear words. Read-only words report the masked status, both globally and per core. Any access that does not match a mapped register and its allowed size is dropped, and a read of such an access returns zero.

The block has no state machine. Each register access is decoded in one step into a register kind: none, route, status, enable, enable-set, enable-clear or core-status. The output stage has a single state register, the 16-bit output word.

Top module: `irq_router`

## Requirements
- R1: After reset all route bytes, the enable register and all 16 outputs are zero.
- R2: A 32-bit read at offset 0x20 returns the current request levels ANDed with the enable register.
- R3: A 32-bit write to 0x28 ORs the data into the enable register. A 32-bit write to 0x2C clears every enable bit that is set in the data. A 32-bit read at 0x24 returns the enable register.
- R4: Byte accesses (`bus_word`=0) to offsets 0x00–0x1F read and write the route byte of request number `offset`. Bits 0–3 of a route byte select cores 0–3, and bits 4–7 select lines 0–3.
- R5: One clock after a change in requests or registers, `irq_out[4*c+y]` equals (some pending request has core bit c) AND (some pending request has line bit y).
- R6: A 32-bit read at 0x40 + 8*c (c = 0..3) returns a word whose bit i is set when request i is high, enabled, and has bit c set in its route byte.
- R7: 32-bit reads at 0x44, 0x4C, 0x54 and 0x5C return zero.
- R8: A 32-bit access whose offset is not a multiple of 4, a 32-bit access to the route region, and a byte access above 0x1F are all ignored on write and read as zero.
- R9: Writes to the status word, the enable read word and the per-core status words change no state.
- R10: Reads at unmapped offsets (for example 0x30, 0x3C, 0x60, 0x7C) return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32 | Level interrupt requests |
| bus_valid | input | 1 | Register access this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_addr | input | 7 | Byte offset |
| bus_wdata | input | 32 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 32 | Read data, valid in the same cycle |
| irq_out | output | 16 | Routed interrupt lines, index 4*core + line |

## Verification
The bench sweeps all 256 values of one route byte and compares the core-by-line fan-out with the outer product of the two nibbles. A design that tracked pairs per request would fail the cross case, where one request supplies the core and another supplies the line, and would hold that output low. The bench also drives each request alone through a fixed route pattern and enable mask. This catches a swapped nibble or a wrong output index, which would raise the transposed line. Wrong-size, misaligned, odd-window and write-to-status accesses are each followed by reads of the state they could have changed. A decoder that treated these as valid would show changed enables or route bytes, or nonzero read data.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_ROUTE,
        RK_STAT,
        RK_ENAB,
        RK_ESET,
        RK_ECLR,
        RK_CORE
    } reg_kind_e;

    localparam int OFF_STAT    = 32'h20;
    localparam int OFF_ENAB    = 32'h24;
    localparam int OFF_ESET    = 32'h28;
    localparam int OFF_ECLR    = 32'h2C;
    localparam int OFF_CORE    = 32'h40;
    localparam int CORE_STRIDE = 8;

endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int N_SRC  = 32,
    parameter int N_CORE = 4,
    parameter int RW     = 8,
    parameter int AW     = 7,
    parameter int DW     = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic                    bus_word,
    input  logic [AW-1:0]           bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic [N_SRC-1:0]        status,
    input  logic [N_CORE*N_SRC-1:0] core_stat,
    output logic [N_SRC*RW-1:0]     route_flat,
    output logic [N_SRC-1:0]        enab
);

    localparam int RIDX_W = $clog2(N_SRC);
    localparam int CIDX_W = $clog2(N_CORE);

    logic [RW-1:0]     route_q [N_SRC];
    logic [N_SRC-1:0]  enab_q;
    reg_kind_e         kind;
    logic [31:0]       a_ext;
    logic [RIDX_W-1:0] ridx;
    logic [CIDX_W-1:0] cidx;
    logic [N_SRC-1:0]  core_word;
    logic              route_we;
    logic              eset_we;
    logic              eclr_we;

    assign a_ext = 32'(bus_addr);
    assign ridx  = bus_addr[RIDX_W-1:0];
    assign cidx  = bus_addr[3 +: CIDX_W];

    // access decode: size and alignment first, then offset
    always_comb begin
        kind = RK_NONE;
        if (!bus_word) begin
            if (a_ext < N_SRC) kind = RK_ROUTE;
        end else if (bus_addr[1:0] == 2'b00) begin
            if (a_ext >= OFF_CORE && a_ext < OFF_CORE + CORE_STRIDE * N_CORE) begin
                if (!bus_addr[2]) kind = RK_CORE;
            end else if (a_ext == OFF_STAT) begin
                kind = RK_STAT;
            end else if (a_ext == OFF_ENAB) begin
                kind = RK_ENAB;
            end else if (a_ext == OFF_ESET) begin
                kind = RK_ESET;
            end else if (a_ext == OFF_ECLR) begin
                kind = RK_ECLR;
            end
        end
    end

    assign route_we = bus_valid && bus_write && (kind == RK_ROUTE);
    assign eset_we  = bus_valid && bus_write && (kind == RK_ESET);
    assign eclr_we  = bus_valid && bus_write && (kind == RK_ECLR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SRC; i++) route_q[i] <= '0;
        end else if (route_we) begin
            route_q[ridx] <= bus_wdata[RW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enab_q <= '0;
        end else if (eset_we) begin
            enab_q <= enab_q | bus_wdata[N_SRC-1:0];
        end else if (eclr_we) begin
            enab_q <= enab_q & ~bus_wdata[N_SRC-1:0];
        end
    end

    always_comb begin
        core_word = '0;
        for (int c = 0; c < N_CORE; c++) begin
            if (cidx == CIDX_W'(c)) core_word = core_stat[c*N_SRC +: N_SRC];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_valid && !bus_write) begin
            unique case (kind)
                RK_ROUTE: bus_rdata = DW'(route_q[ridx]);
                RK_STAT:  bus_rdata = DW'(status);
                RK_ENAB:  bus_rdata = DW'(enab_q);
                RK_CORE:  bus_rdata = DW'(core_word);
                default:  bus_rdata = '0;
            endcase
        end
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_pack
        assign route_flat[i*RW +: RW] = route_q[i];
    end

    assign enab = enab_q;

    // R3: set and clear words act on the enable register
    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        eset_we |=> ((enab & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0])));
    a_r3_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        eclr_we |=> ((enab & $past(bus_wdata[N_SRC-1:0])) == '0));
    // R4, R9: route table changes only on a byte write to the route region
    a_r4_route_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !route_we |=> $stable(route_flat));
    // R8: misaligned word reads return zero
    always_comb begin
        if (rst_n && bus_valid && !bus_write && bus_word && bus_addr[1:0] != 2'b00)
            a_r8_misaligned_zero: assert (bus_rdata == '0);
    end

endmodule

// File: rtl/irq_router_fabric.sv
module irq_router_fabric #(
    parameter int N_SRC  = 32,
    parameter int N_CORE = 4,
    parameter int N_LINE = 4,
    parameter int RW     = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SRC-1:0]         irq_in,
    input  logic [N_SRC-1:0]         enab,
    input  logic [N_SRC*RW-1:0]      route_flat,
    output logic [N_SRC-1:0]         status,
    output logic [N_CORE*N_SRC-1:0]  core_stat,
    output logic [N_CORE*N_LINE-1:0] irq_out
);

    localparam int N_OUT = N_CORE * N_LINE;

    logic [N_SRC-1:0]  pending;
    logic [N_CORE-1:0] core_hit;
    logic [N_LINE-1:0] line_hit;
    logic [N_OUT-1:0]  out_d;
    logic [N_OUT-1:0]  out_q;

    assign pending = irq_in & enab;
    assign status  = pending;

    for (genvar c = 0; c < N_CORE; c++) begin : g_core
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            assign core_stat[c*N_SRC + i] = pending[i] & route_flat[i*RW + c];
        end
        assign core_hit[c] = |core_stat[c*N_SRC +: N_SRC];
    end

    for (genvar y = 0; y < N_LINE; y++) begin : g_line
        logic [N_SRC-1:0] col;
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            assign col[i] = pending[i] & route_flat[i*RW + N_CORE + y];
        end
        assign line_hit[y] = |col;
    end

    for (genvar c = 0; c < N_CORE; c++) begin : g_oc
        for (genvar y = 0; y < N_LINE; y++) begin : g_oy
            assign out_d[c*N_LINE + y] = core_hit[c] & line_hit[y];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign irq_out = out_q;

    // R5: a raised output needs a pending request one cycle earlier
    a_r5_out_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |-> $past(|(irq_in & enab)));
    // R6: per-core status never shows a bit absent from global status
    always_comb begin
        for (int c = 0; c < N_CORE; c++)
            a_r6_core_subset: assert ((core_stat[c*N_SRC +: N_SRC] & ~status) == '0);
    end

endmodule

// File: rtl/irq_router.sv
module irq_router #(
    parameter int N_SRC  = 32,
    parameter int N_CORE = 4,
    parameter int N_LINE = 4,
    parameter int AW     = 7,
    parameter int DW     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_SRC-1:0]         irq_in,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic                     bus_word,
    input  logic [AW-1:0]            bus_addr,
    input  logic [DW-1:0]            bus_wdata,
    output logic [DW-1:0]            bus_rdata,
    output logic [N_CORE*N_LINE-1:0] irq_out
);

    localparam int RW = N_CORE + N_LINE;

    logic [N_SRC-1:0]        status;
    logic [N_CORE*N_SRC-1:0] core_stat;
    logic [N_SRC*RW-1:0]     route_flat;
    logic [N_SRC-1:0]        enab;

    irq_router_regs #(
        .N_SRC(N_SRC), .N_CORE(N_CORE), .RW(RW), .AW(AW), .DW(DW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .status(status), .core_stat(core_stat),
        .route_flat(route_flat), .enab(enab)
    );

    irq_router_fabric #(
        .N_SRC(N_SRC), .N_CORE(N_CORE), .N_LINE(N_LINE), .RW(RW)
    ) u_fabric (
        .clk(clk), .rst_n(rst_n),
        .irq_in(irq_in), .enab(enab), .route_flat(route_flat),
        .status(status), .core_stat(core_stat), .irq_out(irq_out)
    );

    // R1: outputs stay low while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n && $past(!rst_n))
            a_r1_reset_quiet: assert (irq_out == '0);
    end

endmodule

// File: tb/irq_router_tb.sv
module irq_router_tb;

    localparam time CYC = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic        bus_word = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] irq_out;

    int n_checks = 0;
    int n_errs = 0;

    logic [7:0]  m_route [32];
    logic [31:0] m_en;

    always #(CYC/2) clk = ~clk;

    irq_router u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [6:0] a, input logic word, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [6:0] a, input logic word, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_word = word; bus_addr = a;
        #2 d = bus_rdata;
        @(posedge clk); #1;
        bus_valid = 1'b0;
    endtask

    function automatic logic [31:0] exp_core(input int c);
        logic [31:0] r = '0;
        for (int i = 0; i < 32; i++)
            if (irq_in[i] && m_en[i] && m_route[i][c]) r[i] = 1'b1;
        return r;
    endfunction

    function automatic logic [15:0] exp_out();
        logic [15:0] r = '0;
        logic [3:0] ch = '0;
        logic [3:0] lh = '0;
        for (int i = 0; i < 32; i++)
            if (irq_in[i] && m_en[i]) begin
                ch = ch | m_route[i][3:0];
                lh = lh | m_route[i][7:4];
            end
        for (int c = 0; c < 4; c++)
            for (int y = 0; y < 4; y++)
                r[4*c + y] = ch[c] & lh[y];
        return r;
    endfunction

    task automatic check_all(input string tag);
        logic [31:0] d;
        @(posedge clk); #2;
        check({"R5 out ", tag}, 32'(irq_out), 32'(exp_out()));
        bus_rd(7'h20, 1'b1, d);
        check({"R2 status ", tag}, d, irq_in & m_en);
        for (int c = 0; c < 4; c++) begin
            bus_rd(7'(8'h40 + 8*c), 1'b1, d);
            check({"R6 core ", tag}, d, exp_core(c));
        end
    endtask

    initial begin
        #(CYC * 200000);
        n_errs++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 32; i++) m_route[i] = '0;
        m_en = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 outputs", 32'(irq_out), 32'h0);
        bus_rd(7'h24, 1'b1, d);
        check("R1 enable", d, 32'h0);
        for (int i = 0; i < 32; i++) begin
            bus_rd(7'(i), 1'b0, d);
            check("R1 route", d, 32'h0);
        end

        // R4 route table byte write and read back
        for (int i = 0; i < 32; i++) begin
            m_route[i] = 8'((i * 37 + 11) & 8'hFF);
            bus_wr(7'(i), 1'b0, {24'hABCDEF, m_route[i]});
        end
        for (int i = 0; i < 32; i++) begin
            bus_rd(7'(i), 1'b0, d);
            check("R4 route readback", d, {24'h0, m_route[i]});
        end

        // R3 enable set and clear
        bus_wr(7'h28, 1'b1, 32'hF0F0_00FF); m_en = m_en | 32'hF0F0_00FF;
        bus_rd(7'h24, 1'b1, d); check("R3 set", d, m_en);
        bus_wr(7'h28, 1'b1, 32'h0000_FF00); m_en = m_en | 32'h0000_FF00;
        bus_rd(7'h24, 1'b1, d); check("R3 set again", d, m_en);
        bus_wr(7'h2C, 1'b1, 32'h1000_00F0); m_en = m_en & ~32'h1000_00F0;
        bus_rd(7'h24, 1'b1, d); check("R3 clear", d, m_en);

        // R2 R5 R6: each request alone, then mixed patterns
        for (int k = 0; k < 32; k++) begin
            @(negedge clk); irq_in = 32'h1 << k;
            check_all("single");
        end
        @(negedge clk); irq_in = 32'hFFFF_FFFF; check_all("all");
        @(negedge clk); irq_in = 32'hA5A5_5A5A; check_all("mix");
        bus_wr(7'h28, 1'b1, 32'hFFFF_FFFF); m_en = 32'hFFFF_FFFF;
        @(negedge clk); irq_in = 32'h0F0F_3C3C; check_all("full enable");

        // R5 cross pair: core from one request, line from another
        bus_wr(7'h2C, 1'b1, 32'hFFFF_FFFF); m_en = '0;
        bus_wr(7'h03, 1'b0, 32'h01); m_route[3] = 8'h01;
        bus_wr(7'h09, 1'b0, 32'h40); m_route[9] = 8'h40;
        bus_wr(7'h28, 1'b1, 32'h0000_0208); m_en = 32'h0000_0208;
        @(negedge clk); irq_in = 32'h0000_0008; check_all("core only");
        check("R5 core only low", 32'(irq_out), 32'h0);
        @(negedge clk); irq_in = 32'h0000_0208; check_all("cross");
        check("R5 cross line 2", 32'(irq_out), 32'h0000_0004);

        // R4 R5 exhaustive route byte sweep on request 0
        bus_wr(7'h28, 1'b1, 32'h1); m_en = m_en | 32'h1;
        @(negedge clk); irq_in = 32'h1;
        for (int r = 0; r < 256; r++) begin
            logic [15:0] e;
            bus_wr(7'h00, 1'b0, 32'(r)); m_route[0] = 8'(r);
            @(posedge clk); #2;
            for (int c = 0; c < 4; c++)
                for (int y = 0; y < 4; y++)
                    e[4*c + y] = r[c] & r[4 + y];
            check("R4 R5 route sweep", 32'(irq_out), 32'(e));
        end

        // R7 odd words in the per-core window
        @(negedge clk); irq_in = 32'hFFFF_FFFF;
        bus_wr(7'h28, 1'b1, 32'hFFFF_FFFF); m_en = 32'hFFFF_FFFF;
        for (int c = 0; c < 4; c++) begin
            bus_rd(7'(8'h44 + 8*c), 1'b1, d);
            check("R7 odd window", d, 32'h0);
        end

        // R8 wrong size or alignment
        bus_rd(7'h21, 1'b1, d); check("R8 misaligned status", d, 32'h0);
        bus_rd(7'h42, 1'b1, d); check("R8 misaligned core", d, 32'h0);
        bus_rd(7'h20, 1'b0, d); check("R8 byte status", d, 32'h0);
        bus_rd(7'h04, 1'b1, d); check("R8 word route", d, 32'h0);
        bus_wr(7'h2C, 1'b0, 32'hFF);
        bus_wr(7'h2D, 1'b1, 32'hFFFF_FFFF);
        bus_rd(7'h24, 1'b1, d); check("R8 bad clear ignored", d, m_en);
        bus_wr(7'h04, 1'b1, 32'h0);
        bus_rd(7'h04, 1'b0, d); check("R8 word route write ignored", d, {24'h0, m_route[4]});

        // R9 writes to read-only words
        bus_wr(7'h40, 1'b1, 32'h0);
        bus_wr(7'h20, 1'b1, 32'h0);
        bus_wr(7'h24, 1'b1, 32'h0);
        bus_rd(7'h24, 1'b1, d); check("R9 enable unchanged", d, m_en);
        check_all("after ro writes");
        bus_rd(7'h40, 1'b1, d); check("R9 core0 recomputed", d, exp_core(0));

        // R10 unmapped offsets
        bus_rd(7'h30, 1'b1, d); check("R10 0x30", d, 32'h0);
        bus_rd(7'h3C, 1'b1, d); check("R10 0x3C", d, 32'h0);
        bus_rd(7'h60, 1'b1, d); check("R10 0x60", d, 32'h0);
        bus_rd(7'h7C, 1'b1, d); check("R10 0x7C", d, 32'h0);
        bus_rd(7'h28, 1'b1, d); check("R10 set word reads zero", d, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule